// File: doc/BRIEF.md
# Dual Parity Generator with Word Compare

This block holds two independent nine-input parity halves, called A and B, and one shared word-equality output. Each half takes eight data bits and an expansion bit. Its output is high when an even number of those nine bits are high. The expansion bit joins at the last XOR stage, so it has the shortest path through the logic. That makes it the natural place to feed the parity of another half when building parity over 16 bits or more.

The compare output reads the even-numbered inputs of both halves as one 8-bit word and the odd-numbered inputs as a second 8-bit word. It goes low only when the two words match in every bit position.

A built-in chain of halves shows the cascade. Each stage's parity output drives the next stage's expansion bit, and the last stage is corrected for its inversion so that the result is even-high over the whole chain width.

An optional register stage captures the inputs and the outputs on rising clock edges, which makes the block easy to test with a clock. When `REGISTERED` is 0, the block is purely combinational.

Top module: `dual_parity_cmp`

## Requirements
- R1: With `REGISTERED`=1, a rising edge with `rst` high clears every output register to 0, so `parityA`, `parityB`, `cmpN` and `chainEven` all read 0 after that edge.
- R2: `parityA` is 1 when the count of high bits among `dataA[7:0]` and `expA` is even, and 0 when the count is odd.
- R3: `parityB` follows the same even-high rule over `dataB[7:0]` and `expB`, and depends on no input of half A.
- R4: With the expansion bit at 0, a half's parity is the even-high parity of its eight data bits alone. Raising the expansion bit inverts that half's parity output.
- R5: `cmpN` is 0 exactly when `dataA[0]==dataA[1]`, `dataA[2]==dataA[3]`, `dataA[4]==dataA[5]`, `dataA[6]==dataA[7]` and the same four pairs of `dataB` all hold. Any unequal pair makes it 1.
- R6: `expA` and `expB` have no effect on `cmpN`.
- R7: `chainEven` is 1 when the count of high bits in `chainData` is even and 0 when it is odd, for any `CHAIN_STAGES` of at least 1.
- R8: With `REGISTERED`=1, an input applied before a rising edge appears on the outputs after the second rising edge, and the outputs keep their previous values after only the first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional register stage |
| rst | input | 1 | Synchronous active-high reset that clears the registers |
| dataA | input | DATA_W (8) | Data bits of half A |
| expA | input | 1 | Expansion bit of half A |
| dataB | input | DATA_W (8) | Data bits of half B |
| expB | input | 1 | Expansion bit of half B |
| chainData | input | CHAIN_STAGES*DATA_W (16) | Data bits feeding the cascaded chain |
| parityA | output | 1 | Even-high parity of half A |
| parityB | output | 1 | Even-high parity of half B |
| cmpN | output | 1 | Low when the even-bit word equals the odd-bit word |
| chainEven | output | 1 | Even-high parity over the whole chain width |

## Verification
Every one of the 512 combinations of half A's nine inputs is applied. Half B receives the complement at the same time, which shows that each half follows its own popcount and not its neighbour's. The compare output is tried with equal word pairs and with pairs that differ in exactly one bit position, one position per pattern. This shows that each of the eight pairs is wired in and that the expansion bits are left out. A further set of mixed vectors covers the chain's even-high correction. Directed steps then check the cleared state on reset and the two-edge latency, by holding one vector and watching the outputs change only on the second edge.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
  typedef struct packed {
    logic clear;
    logic load;
  } dpcStrobes_t;
endpackage

// File: rtl/dpc_parity_half.sv
module dpc_parity_half #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data,
  input  logic              expIn,
  output logic              evenOut
);
  logic treeOdd;

  // Data bits reduce first; the expansion bit enters only the last XOR.
  always_comb begin
    treeOdd = ^data;
    evenOut = ~(treeOdd ^ expIn);
  end
endmodule

// File: rtl/dpc_compare.sv
module dpc_compare #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] dataA,
  input  logic [DATA_W-1:0] dataB,
  output logic              mismatch
);
  localparam int PAIRS = DATA_W / 2;

  logic [PAIRS-1:0] diffA;
  logic [PAIRS-1:0] diffB;

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    assign diffA[p] = dataA[2*p] ^ dataA[2*p+1];
    assign diffB[p] = dataB[2*p] ^ dataB[2*p+1];
  end

  assign mismatch = (|diffA) | (|diffB);
endmodule

// File: rtl/dpc_ctrl.sv
module dpc_ctrl
  import dpc_pkg::*;
(
  input  logic        rst,
  output dpcStrobes_t strobes
);
  always_comb begin
    strobes.clear = rst;
    strobes.load  = ~rst;
  end
endmodule

// File: rtl/dpc_datapath.sv
module dpc_datapath
  import dpc_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int CHAIN_STAGES = 2,
  parameter bit REGISTERED   = 1'b1
) (
  input  logic                           clk,
  input  dpcStrobes_t                    strobes,
  input  logic [DATA_W-1:0]              dataA,
  input  logic                           expA,
  input  logic [DATA_W-1:0]              dataB,
  input  logic                           expB,
  input  logic [CHAIN_STAGES*DATA_W-1:0] chainData,
  output logic                           parityA,
  output logic                           parityB,
  output logic                           cmpN,
  output logic                           chainEven
);
  localparam int  CHAIN_W  = CHAIN_STAGES * DATA_W;
  localparam bit  FIX_LAST = (CHAIN_STAGES % 2) == 0;

  logic [DATA_W-1:0]  inA, inB;
  logic               inExpA, inExpB;
  logic [CHAIN_W-1:0] inChain;
  logic               combA, combB, combCmp, combChain;

  // Optional input capture
  if (REGISTERED) begin : g_inReg
    always_ff @(posedge clk) begin
      if (strobes.clear) begin
        inA     <= '0;
        inB     <= '0;
        inExpA  <= 1'b0;
        inExpB  <= 1'b0;
        inChain <= '0;
      end else if (strobes.load) begin
        inA     <= dataA;
        inB     <= dataB;
        inExpA  <= expA;
        inExpB  <= expB;
        inChain <= chainData;
      end
    end
  end else begin : g_inWire
    always_comb begin
      inA     = dataA;
      inB     = dataB;
      inExpA  = expA;
      inExpB  = expB;
      inChain = chainData;
    end
  end

  dpc_parity_half #(.DATA_W(DATA_W)) u_halfA (
    .data(inA), .expIn(inExpA), .evenOut(combA)
  );

  dpc_parity_half #(.DATA_W(DATA_W)) u_halfB (
    .data(inB), .expIn(inExpB), .evenOut(combB)
  );

  dpc_compare #(.DATA_W(DATA_W)) u_cmp (
    .dataA(inA), .dataB(inB), .mismatch(combCmp)
  );

  // Cascade: each stage's output feeds the next stage's expansion bit
  logic [CHAIN_STAGES:0] link;
  assign link[0] = 1'b0;
  for (genvar s = 0; s < CHAIN_STAGES; s++) begin : g_stage
    dpc_parity_half #(.DATA_W(DATA_W)) u_stage (
      .data   (inChain[s*DATA_W +: DATA_W]),
      .expIn  (link[s]),
      .evenOut(link[s+1])
    );
  end
  // Stage outputs alternate between even-high and odd-high
  assign combChain = link[CHAIN_STAGES] ^ FIX_LAST;

  // Optional output capture
  if (REGISTERED) begin : g_outReg
    always_ff @(posedge clk) begin
      if (strobes.clear) begin
        parityA   <= 1'b0;
        parityB   <= 1'b0;
        cmpN      <= 1'b0;
        chainEven <= 1'b0;
      end else if (strobes.load) begin
        parityA   <= combA;
        parityB   <= combB;
        cmpN      <= combCmp;
        chainEven <= combChain;
      end
    end
  end else begin : g_outWire
    always_comb begin
      parityA   = combA;
      parityB   = combB;
      cmpN      = combCmp;
      chainEven = combChain;
    end
  end
endmodule

// File: rtl/dual_parity_cmp.sv
module dual_parity_cmp
  import dpc_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int CHAIN_STAGES = 2,
  parameter bit REGISTERED   = 1'b1
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [DATA_W-1:0]              dataA,
  input  logic                           expA,
  input  logic [DATA_W-1:0]              dataB,
  input  logic                           expB,
  input  logic [CHAIN_STAGES*DATA_W-1:0] chainData,
  output logic                           parityA,
  output logic                           parityB,
  output logic                           cmpN,
  output logic                           chainEven
);
  dpcStrobes_t strobes;

  dpc_ctrl u_ctrl (
    .rst(rst), .strobes(strobes)
  );

  dpc_datapath #(
    .DATA_W(DATA_W), .CHAIN_STAGES(CHAIN_STAGES), .REGISTERED(REGISTERED)
  ) u_dp (
    .clk(clk), .strobes(strobes),
    .dataA(dataA), .expA(expA), .dataB(dataB), .expB(expB),
    .chainData(chainData),
    .parityA(parityA), .parityB(parityB), .cmpN(cmpN), .chainEven(chainEven)
  );
endmodule

// File: rtl/dual_parity_cmp_chk.sv
module dual_parity_cmp_chk #(
  parameter int DATA_W       = 8,
  parameter int CHAIN_STAGES = 2,
  parameter bit REGISTERED   = 1'b1
) (
  input logic                           clk,
  input logic                           rst,
  input logic [DATA_W-1:0]              dataA,
  input logic                           expA,
  input logic [DATA_W-1:0]              dataB,
  input logic                           expB,
  input logic [CHAIN_STAGES*DATA_W-1:0] chainData,
  input logic                           parityA,
  input logic                           parityB,
  input logic                           cmpN,
  input logic                           chainEven
);
  localparam int PAIRS = DATA_W / 2;

  // Counts clean edges since reset; results are valid once it reaches 2
  logic [1:0] warm;
  always_ff @(posedge clk) begin
    if (rst) warm <= 2'd0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  function automatic logic pairsDiffer(input logic [DATA_W-1:0] a,
                                       input logic [DATA_W-1:0] b);
    logic d;
    d = 1'b0;
    for (int p = 0; p < PAIRS; p++) d |= (a[2*p] != a[2*p+1]) | (b[2*p] != b[2*p+1]);
    return d;
  endfunction

  if (REGISTERED) begin : g_seq
    AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> (!parityA && !parityB && !cmpN && !chainEven)); // R1
    AST_PARITY_A: assert property (@(posedge clk) disable iff (rst)
      (warm >= 2'd2) |-> parityA == (($countones($past(dataA, 2)) + $past(expA, 2)) % 2 == 0)); // R2
    AST_PARITY_B: assert property (@(posedge clk) disable iff (rst)
      (warm >= 2'd2) |-> parityB == (($countones($past(dataB, 2)) + $past(expB, 2)) % 2 == 0)); // R3
    AST_COMPARE: assert property (@(posedge clk) disable iff (rst)
      (warm >= 2'd2) |-> cmpN == pairsDiffer($past(dataA, 2), $past(dataB, 2))); // R5
    AST_CHAIN_EVEN: assert property (@(posedge clk) disable iff (rst)
      (warm >= 2'd2) |-> chainEven == ($countones($past(chainData, 2)) % 2 == 0)); // R7
  end else begin : g_comb
    AST_PARITY_A: assert property (@(posedge clk)
      parityA == (($countones(dataA) + expA) % 2 == 0)); // R2
    AST_PARITY_B: assert property (@(posedge clk)
      parityB == (($countones(dataB) + expB) % 2 == 0)); // R3
    AST_COMPARE: assert property (@(posedge clk)
      cmpN == pairsDiffer(dataA, dataB)); // R5
    AST_CHAIN_EVEN: assert property (@(posedge clk)
      chainEven == ($countones(chainData) % 2 == 0)); // R7
  end
endmodule

bind dual_parity_cmp dual_parity_cmp_chk #(
  .DATA_W(DATA_W), .CHAIN_STAGES(CHAIN_STAGES), .REGISTERED(REGISTERED)
) u_chk (
  .clk(clk), .rst(rst), .dataA(dataA), .expA(expA), .dataB(dataB), .expB(expB),
  .chainData(chainData), .parityA(parityA), .parityB(parityB), .cmpN(cmpN),
  .chainEven(chainEven)
);

// File: tb/dual_parity_cmp_tb.sv
module dual_parity_cmp_tb;
  localparam int DW = 8;
  localparam int CS = 2;
  localparam int CW = DW * CS;
  localparam int NVEC = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [DW-1:0] dataA = '0, dataB = '0;
  logic expA = 1'b0, expB = 1'b0;
  logic [CW-1:0] chainData = '0;
  logic parityA, parityB, cmpN, chainEven;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  dual_parity_cmp #(.DATA_W(DW), .CHAIN_STAGES(CS), .REGISTERED(1'b1)) u_dut (
    .clk(clk), .rst(rst), .dataA(dataA), .expA(expA), .dataB(dataB), .expB(expB),
    .chainData(chainData), .parityA(parityA), .parityB(parityB), .cmpN(cmpN),
    .chainEven(chainEven)
  );

  // {dataA, expA, dataB, expB, chainData}
  localparam logic [2*DW+2+CW-1:0] VEC [NVEC] = '{
    34'h0_0000_0000, 34'h3_FFFF_FFFF, 34'h1_5555_5555, 34'h2_AAAA_AAAA,
    34'h0_C030_0001, 34'h1_2345_6789, 34'h2_FEDC_BA98, 34'h0_0F0F_F0F0,
    34'h3_0000_8000, 34'h1_8001_0003, 34'h2_7C3E_1234, 34'h0_33CC_FFFE
  };

  function automatic logic evenOf(input logic [63:0] v);
    return ($countones(v) % 2) == 0;
  endfunction

  function automatic logic pairMismatch(input logic [DW-1:0] a, input logic [DW-1:0] b);
    logic m;
    m = 1'b0;
    for (int p = 0; p < DW/2; p++)
      if (a[2*p] != a[2*p+1] || b[2*p] != b[2*p+1]) m = 1'b1;
    return m;
  endfunction

  task automatic check(input string req, input string what,
                       input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [DW-1:0] a, input logic ea,
                       input logic [DW-1:0] b, input logic eb,
                       input logic [CW-1:0] c);
    @(negedge clk);
    dataA = a; expA = ea; dataB = b; expB = eb; chainData = c;
    @(posedge clk);
    @(posedge clk);
    #5;
  endtask

  // Builds dataA/dataB so word w0 sits on even bits and w1 on odd bits
  task automatic applyWords(input logic [DW-1:0] w0, input logic [DW-1:0] w1,
                            input logic ea, input logic eb);
    logic [DW-1:0] a, b;
    for (int i = 0; i < DW/2; i++) begin
      a[2*i] = w0[i];        a[2*i+1] = w1[i];
      b[2*i] = w0[i+DW/2];   b[2*i+1] = w1[i+DW/2];
    end
    apply(a, ea, b, eb, '0);
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    // R1: outputs cleared while reset is applied
    repeat (3) @(posedge clk);
    #5;
    check("R1", "parityA in reset", parityA, 1'b0);
    check("R1", "parityB in reset", parityB, 1'b0);
    check("R1", "cmpN in reset", cmpN, 1'b0);
    check("R1", "chainEven in reset", chainEven, 1'b0);
    @(negedge clk);
    rst = 1'b0;

    // Vector table
    for (int v = 0; v < NVEC; v++) begin
      logic [DW-1:0] a, b;
      logic ea, eb;
      logic [CW-1:0] c;
      {a, ea, b, eb, c} = VEC[v];
      apply(a, ea, b, eb, c);
      check("R2", "table parityA", parityA, evenOf({55'd0, ea, a}));
      check("R3", "table parityB", parityB, evenOf({55'd0, eb, b}));
      check("R5", "table cmpN", cmpN, pairMismatch(a, b));
      check("R7", "table chainEven", chainEven, evenOf({48'd0, c}));
    end

    // Exhaustive half A; half B gets the complement (R2, R3, R4)
    for (int v = 0; v < 512; v++) begin
      logic [8:0] n;
      n = 9'(v);
      apply(n[7:0], n[8], ~n[7:0], ~n[8], {n[7:0], ~n[7:0]});
      check("R2", "sweep parityA", parityA, evenOf({55'd0, n}));
      check("R3", "sweep parityB", parityB, evenOf({55'd0, ~n}));
      if (!n[8]) check("R4", "exp low data-only parity", parityA, evenOf({56'd0, n[7:0]}));
      check("R7", "sweep chainEven", chainEven, evenOf({48'd0, n[7:0], ~n[7:0]}));
    end

    // R4: raising the expansion bit inverts
    apply(8'h07, 1'b0, 8'h00, 1'b0, '0);
    check("R4", "exp=0 odd data", parityA, 1'b0);
    apply(8'h07, 1'b1, 8'h00, 1'b1, '0);
    check("R4", "exp=1 odd data", parityA, 1'b1);
    check("R4", "exp=1 zero data B", parityB, 1'b0);

    // R5/R6: equal words and single-bit differences
    for (int w = 0; w < 4; w++) begin
      logic [DW-1:0] word;
      word = 8'(w * 8'h5B + 8'h19);
      applyWords(word, word, 1'b0, 1'b0);
      check("R5", "equal words", cmpN, 1'b0);
      applyWords(word, word, 1'b1, 1'b1);
      check("R6", "equal words exp high", cmpN, 1'b0);
      applyWords(word, word, 1'b1, 1'b0);
      check("R6", "equal words expA only", cmpN, 1'b0);
      for (int bit_i = 0; bit_i < DW; bit_i++) begin
        applyWords(word, word ^ (8'd1 << bit_i), 1'b0, 1'b0);
        check("R5", "one-bit difference", cmpN, 1'b1);
      end
    end
    applyWords(8'hA5, 8'h5A, 1'b1, 1'b1);
    check("R6", "differing words exp high", cmpN, 1'b1);

    // R8: two-edge latency
    apply(8'h00, 1'b0, 8'h00, 1'b0, '0);
    @(negedge clk);
    dataA = 8'h01;
    @(posedge clk);
    #5;
    check("R8", "after first edge", parityA, 1'b1);
    @(posedge clk);
    #5;
    check("R8", "after second edge", parityA, 1'b0);

    // R1: reset after activity
    apply(8'h03, 1'b0, 8'h01, 1'b0, 16'h0001);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #5;
    check("R1", "parityA after reset", parityA, 1'b0);
    check("R1", "parityB after reset", parityB, 1'b0);
    check("R1", "cmpN after reset", cmpN, 1'b0);
    check("R1", "chainEven after reset", chainEven, 1'b0);
    @(negedge clk);
    rst = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule